// File: doc/BRIEF.md
# Message-Based Interrupt Mailbox Controller

This block carries interrupts between agents on a shared system bus as small addressed messages rather than as dedicated wires. The local processor fills a 4-byte outgoing message one byte at a time through a byte-wide register port. It then issues a send command. The block requests the bus, waits for a grant, presents the whole 32-bit message and finishes when the receiver signals ready.

On the receive side the block looks at every 32-bit transfer offered on the bus. It accepts a transfer only when the destination byte matches its own agent address and its queue has space. Accepted messages are held whole in a small first-in first-out queue. While any message is waiting, an interrupt line to the processor stays high. The processor drains each message byte by byte through a pop port, and the interrupt falls once the last waiting message has been read out.

Top module: `msgIntrCtl`

## Requirements
- R1: A message word is packed with byte k at bits 8k+7:8k: byte 0 is the source, byte 1 the destination, byte 2 the type and byte 3 a data byte. Writing register offsets 0 to 3 (chip select low, write strobe low) sets message byte 0 to 3, and reading those offsets returns the stored byte.
- R2: A write to offset 4 while idle raises `txReq` after the next clock edge. `txDrive` rises only in the cycle after `txGrant` is sampled high, and while `txDrive` is high `txData` carries the packed message. The first clock edge with `txReady` high ends the transfer and drops both `txReq` and `txDrive`.
- R3: A write to offset 4 while a transfer is busy starts nothing. It sets a sticky flag at status bit 1, and the flag is cleared by the next read of the status register.
- R4: A write to offsets 0 to 3 while a transfer is busy is stretched with `waitN` low. The stored byte and `txData` stay unchanged until the transfer ends, and the write then completes.
- R5: When `rxValid` is high, `rxData[15:8]` equals `agentAddr` and the queue is not full, `rxReady` is high and the message is stored at that clock edge.
- R6: A transfer whose destination byte differs from `agentAddr` gets `rxReady` low and is not stored.
- R7: The queue holds 4 messages. When it is full, `rxReady` stays low for a matching transfer and the stored messages are kept unchanged.
- R8: Each read of offset 6 returns one byte of the oldest message, byte 0 first. After its byte 3 has been read, that entry is freed, and messages come out in arrival order.
- R9: `msgIntr` is high while at least one message is queued. It falls at the clock edge that reads byte 3 of the last queued message.
- R10: Status (offset 5) holds transmit busy at bit 0, the sticky flag at bit 1, the queued count at bits 4:2, queue full at bit 5, and zero at bits 7:6. After reset the status reads 0, `txReq`, `txDrive` and `msgIntr` are low and `waitN` is high.
- R11: A read of offset 6 with an empty queue returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Register port select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 3 | Register offset |
| dataIn | input | 8 | Write data from the processor |
| dataOut | output | 8 | Read data to the processor |
| waitN | output | 1 | Access stretch, active low |
| msgIntr | output | 1 | Message pending interrupt |
| agentAddr | input | 8 | Own agent address for receive matching |
| txReq | output | 1 | Bus request for an outgoing message |
| txGrant | input | 1 | Bus grant |
| txDrive | output | 1 | Outgoing message valid on txData |
| txData | output | 32 | Outgoing message word |
| txReady | input | 1 | Receiver has taken the outgoing message |
| rxValid | input | 1 | Incoming transfer offered |
| rxData | input | 32 | Incoming message word |
| rxReady | output | 1 | Incoming transfer accepted |

## Verification
The bench builds the block with its default parameters: a queue depth of 4 and 8-bit agent addresses. At that depth, four matching transfers fill the queue, so the refused fifth transfer and the full flag can be observed. Draining all four messages then brings out arrival order, byte order and the exact edge where the interrupt falls. Holding the grant low for several cycles keeps a transfer busy long enough to watch a repeated send and a stretched byte write while it is in flight.

// File: rtl/msgIntrPkg.sv
package msgIntrPkg;
  localparam int unsigned MSG_BYTES = 4;
  localparam int unsigned MSG_W     = 8 * MSG_BYTES;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_REQ   = 2'd1,
    TX_DRIVE = 2'd2
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [MSG_BYTES-1:0] txByteWe;
    logic                 push;
    logic                 pop;
  } strobe_t;
endpackage

// File: rtl/msgIntrCtrl.sv
module msgIntrCtrl
  import msgIntrPkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [2:0]        addr,
  input  logic [ADDR_W-1:0] agentAddr,
  input  logic [ADDR_W-1:0] rxDest,
  input  logic              rxValid,
  input  logic              txGrant,
  input  logic              txReady,
  input  logic [CNT_W-1:0]  qCount,
  input  logic              qFull,
  output strobe_t           strobe,
  output logic [1:0]        rdIdx,
  output logic              txBusy,
  output logic              sendDropped,
  output logic              waitN,
  output logic              txReq,
  output logic              txDrive,
  output logic              rxReady
);
  txState_e txState;
  logic accPrev, access, accStart, rdStart, wrStart;
  logic sendCmd, popRead, statRead, match;

  assign access   = !csN && (!rdN || !wrN);
  assign accStart = access && !accPrev;
  assign rdStart  = accStart && !rdN;
  assign wrStart  = accStart && !wrN;
  assign sendCmd  = wrStart && (addr == 3'd4);
  assign statRead = rdStart && (addr == 3'd5);
  assign popRead  = rdStart && (addr == 3'd6) && (qCount != '0);
  assign match    = (rxDest == agentAddr);

  assign txBusy  = (txState != TX_IDLE);
  assign txReq   = txBusy;
  assign txDrive = (txState == TX_DRIVE);
  assign waitN   = !(!csN && !wrN && !addr[2] && txBusy);
  assign rxReady = rxValid && match && !qFull;

  always_comb begin
    strobe = '0;
    for (int k = 0; k < MSG_BYTES; k++)
      strobe.txByteWe[k] = !csN && !wrN && (addr == 3'(k)) && !txBusy;
    strobe.push = rxReady;
    strobe.pop  = popRead && (rdIdx == 2'd3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accPrev     <= 1'b0;
      txState     <= TX_IDLE;
      rdIdx       <= '0;
      sendDropped <= 1'b0;
    end else begin
      accPrev <= access;
      if (popRead) rdIdx <= rdIdx + 2'd1;
      if (sendCmd && txBusy) sendDropped <= 1'b1;
      else if (statRead)     sendDropped <= 1'b0;
      unique case (txState)
        TX_IDLE:  if (sendCmd) txState <= TX_REQ;
        TX_REQ:   if (txGrant) txState <= TX_DRIVE;
        TX_DRIVE: if (txReady) txState <= TX_IDLE;
        default:  txState <= TX_IDLE;
      endcase
    end
  end

  p_drive_after_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDrive) |-> $past(txGrant));
  p_req_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txDrive) |=> txReq);
  p_refuse_when_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    qFull |-> !rxReady);
  p_ignore_foreign_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && (rxDest != agentAddr)) |-> !rxReady);
endmodule

// File: rtl/msgIntrData.sv
module msgIntrData
  import msgIntrPkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [2:0]       addr,
  input  logic [7:0]       dataIn,
  input  logic [MSG_W-1:0] rxData,
  input  logic [1:0]       rdIdx,
  input  logic             txBusy,
  input  logic             sendDropped,
  output logic [7:0]       dataOut,
  output logic [MSG_W-1:0] txData,
  output logic [CNT_W-1:0] qCount,
  output logic             qFull,
  output logic             msgIntr
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       txByte [MSG_BYTES];
  logic [MSG_W-1:0] queue  [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [MSG_W-1:0] headMsg;
  logic [7:0]       status;

  for (genvar k = 0; k < MSG_BYTES; k++) begin : g_txByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  txByte[k] <= '0;
      else if (strobe.txByteWe[k]) txByte[k] <= dataIn;
    end
    assign txData[8*k +: 8] = txByte[k];
  end

  always_ff @(posedge clk) begin
    if (strobe.push) queue[wrPtr] <= rxData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      qCount <= qCount + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
    end
  end

  assign qFull   = (qCount == CNT_W'(DEPTH));
  assign msgIntr = (qCount != '0);
  assign headMsg = queue[rdPtr];
  assign status  = {2'b00, qFull, 3'(qCount), sendDropped, txBusy};

  always_comb begin
    dataOut = '0;
    case (addr)
      3'd0, 3'd1, 3'd2, 3'd3: dataOut = txByte[addr[1:0]];
      3'd5:                   dataOut = status;
      3'd6:                   if (msgIntr) dataOut = headMsg[8*rdIdx +: 8];
      default:                dataOut = '0;
    endcase
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !qFull);
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (qCount != '0));
  p_intr_after_push_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> msgIntr);
  p_tx_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && $past(txBusy)) |-> $stable(txData));
endmodule

// File: rtl/msgIntrCtl.sv
module msgIntrCtl
  import msgIntrPkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [2:0]        addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              waitN,
  output logic              msgIntr,
  input  logic [ADDR_W-1:0] agentAddr,
  output logic              txReq,
  input  logic              txGrant,
  output logic              txDrive,
  output logic [31:0]       txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [31:0]       rxData,
  output logic              rxReady
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  strobe_t          strobe;
  logic [1:0]       rdIdx;
  logic             txBusy, sendDropped, qFull;
  logic [CNT_W-1:0] qCount;

  msgIntrCtrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .csN, .rdN, .wrN, .addr, .agentAddr,
    .rxDest(rxData[8 +: ADDR_W]), .rxValid, .txGrant, .txReady,
    .qCount, .qFull, .strobe, .rdIdx, .txBusy, .sendDropped,
    .waitN, .txReq, .txDrive, .rxReady
  );

  msgIntrData #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_data (
    .clk, .rstN, .strobe, .addr, .dataIn, .rxData, .rdIdx, .txBusy,
    .sendDropped, .dataOut, .txData, .qCount, .qFull, .msgIntr
  );
endmodule

// File: tb/test_msgIntrCtl.sv
module test_msgIntrCtl;
  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] dataIn = '0, dataOut;
  logic waitN, msgIntr, txReq, txDrive, rxReady;
  logic [7:0] agentAddr = 8'h5A;
  logic txGrant = 1'b0, txReady = 1'b0, rxValid = 1'b0;
  logic [31:0] txData, rxData = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  msgIntrCtl i_msgIntrCtl (
    .clk, .rstN, .csN, .rdN, .wrN, .addr, .dataIn, .dataOut, .waitN,
    .msgIntr, .agentAddr, .txReq, .txGrant, .txDrive, .txData, .txReady,
    .rxValid, .rxData, .rxReady
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); csN = 1'b0; wrN = 1'b0; addr = a; dataIn = d;
    #5;
    while (!waitN) begin @(negedge clk); #5; end
    @(negedge clk); csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic cpuRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); csN = 1'b0; rdN = 1'b0; addr = a;
    #5 d = dataOut;
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic offerRx(input logic [31:0] m, input logic expReady, input string req);
    @(negedge clk); rxValid = 1'b1; rxData = m;
    #5 chk(req, rxReady, expReady);
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic testReset;
    logic [7:0] d;
    chk("R10 txReq", txReq, 0); chk("R10 txDrive", txDrive, 0);
    chk("R10 msgIntr", msgIntr, 0); chk("R10 waitN", waitN, 1);
    cpuRead(3'd5, d); chk("R10 status", d, 8'h00);
  endtask

  task automatic testTxBytes;
    logic [7:0] d;
    cpuWrite(3'd0, 8'h11); cpuWrite(3'd1, 8'h22);
    cpuWrite(3'd2, 8'h33); cpuWrite(3'd3, 8'h44);
    for (int k = 0; k < 4; k++) begin
      cpuRead(3'(k), d); chk("R1 readback", d, 8'h11 * (k + 1));
    end
    chk("R1 packing", txData, 32'h44332211);
  endtask

  task automatic testSendBusy;
    logic [7:0] d;
    cpuWrite(3'd4, 8'h00);
    #5 chk("R2 req raised", txReq, 1); chk("R2 no drive before grant", txDrive, 0);
    cpuWrite(3'd4, 8'h00);  // repeated send while busy
    cpuRead(3'd5, d); chk("R3 sticky set", d, 8'h03);
    cpuRead(3'd5, d); chk("R3 sticky cleared", d, 8'h01);
    fork
      cpuWrite(3'd0, 8'hEE);
      begin
        repeat (3) @(negedge clk);
        #5 chk("R4 wait low", waitN, 0);
        chk("R4 byte frozen", txData, 32'h44332211);
        @(negedge clk); txGrant = 1'b1;
        @(negedge clk); txGrant = 1'b0;
        #5 chk("R2 drive after grant", txDrive, 1);
        chk("R2 message on bus", txData, 32'h44332211);
        @(negedge clk); txReady = 1'b1;
        @(negedge clk); txReady = 1'b0;
        #5 chk("R2 drive dropped", txDrive, 0); chk("R2 req dropped", txReq, 0);
      end
    join
    cpuRead(3'd0, d); chk("R4 write landed", d, 8'hEE);
    cpuRead(3'd5, d); chk("R3 single transfer idle", d, 8'h00);
  endtask

  task automatic testRxMatch;
    logic [7:0] d;
    offerRx(32'hC4B35A01, 1'b0 ? 1'b0 : 1'b1, "R5 accept match");
    offerRx(32'h99887766, 1'b0, "R6 refuse foreign");
    cpuRead(3'd5, d); chk("R6 count one", d, 8'h04);
    chk("R9 intr set", msgIntr, 1);
    cpuRead(3'd6, d); chk("R8 byte0", d, 8'h01);
    cpuRead(3'd6, d); chk("R8 byte1", d, 8'h5A);
    cpuRead(3'd6, d); chk("R8 byte2", d, 8'hB3);
    chk("R9 intr held", msgIntr, 1);
    cpuRead(3'd6, d); chk("R8 byte3", d, 8'hC4);
    chk("R9 intr dropped", msgIntr, 0);
    cpuRead(3'd6, d); chk("R11 empty pop", d, 8'h00);
    cpuRead(3'd5, d); chk("R11 status unchanged", d, 8'h00);
  endtask

  task automatic testFull;
    logic [7:0] d;
    for (int k = 0; k < 4; k++)
      offerRx({8'hD0 + 8'(k), 8'h30 + 8'(k), 8'h5A, 8'h10 + 8'(k)}, 1'b1, "R7 fill");
    cpuRead(3'd5, d); chk("R7 full status", d, 8'h30);
    offerRx(32'hFFFF5AFF, 1'b0, "R7 refuse when full");
    for (int k = 0; k < 4; k++) begin
      cpuRead(3'd6, d); chk("R8 order src", d, 8'h10 + 8'(k));
      cpuRead(3'd6, d); chk("R8 order dest", d, 8'h5A);
      cpuRead(3'd6, d); chk("R8 order type", d, 8'h30 + 8'(k));
      cpuRead(3'd6, d); chk("R7 kept data", d, 8'hD0 + 8'(k));
    end
    chk("R9 intr after drain", msgIntr, 0);
    cpuRead(3'd5, d); chk("R10 status empty", d, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTxBytes();
    testSendBusy();
    testRxMatch();
    testFull();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule